// File: doc/BRIEF.md
# Receive FIFO with Hysteresis Flow Control

This block buffers bytes coming out of a serial receiver until software reads them one at a time. Incoming bytes are written on a valid strobe; the oldest byte is always presented on the read data output, and a read request removes it. The block reports its occupancy as a 6-bit level together with empty, full and threshold flags. It also keeps two sticky error flags, one for a byte lost to a full buffer and one for any illegal pointer access.

The occupancy also drives the request-to-send output. RTS reacts only when the level crosses a threshold. Rising into the high threshold raises RTS, which asks the far end to pause. Falling into the low threshold drops RTS, which asks the far end to resume. Between the two thresholds RTS keeps its last value. When occupancy control is disabled, RTS is passed through from an external handshake source. Software must keep the low threshold at or below the high threshold. The depth is a parameter of 8 to 63 entries.

Top module: `rx_fifo_rts`

## Requirements
- R1: After reset, level_o is 0, empty_o is 1, full_o is 0, overrun_o and ptr_err_o are 0, and the internal RTS state is 0 (ready to receive).
- R2: Bytes leave in the order they were written. rd_data_o shows the oldest stored byte whenever empty_o is 0. An accepted write adds 1 to level_o and an accepted read subtracts 1, both at the next clock edge.
- R3: A write while full_o is 1 is dropped. The stored contents and level_o do not change, and both overrun_o and ptr_err_o are set and stay set.
- R4: A read while empty_o is 1 leaves level_o at 0 and sets ptr_err_o.
- R5: clear_i empties the buffer (level_o becomes 0), clears overrun_o and ptr_err_o, and takes priority over a write or read in the same cycle.
- R6: When an edge takes the level from below thr_high_i to at least thr_high_i, the RTS state becomes 1 at that edge.
- R7: When an edge takes the level from above thr_low_i to at most thr_low_i, the RTS state becomes 0 at that edge.
- R8: When the new level is strictly between thr_low_i and thr_high_i, the RTS state keeps its previous value.
- R9: rts_o equals the RTS state while rts_ctrl_en_i is 1, and equals rts_base_i while it is 0.
- R10: thr_high_flag_o is 1 exactly when level_o >= thr_high_i, and thr_low_flag_o is 1 exactly when level_o <= thr_low_i.
- R11: While fifo_en_i is 0, the buffer is held empty, and writes and reads are ignored without setting any error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | Buffer enable |
| rts_ctrl_en_i | input | 1 | Selects occupancy-driven RTS |
| rts_base_i | input | 1 | RTS value used when occupancy control is off |
| thr_high_i | input | 6 | High threshold (stop sending) |
| thr_low_i | input | 6 | Low threshold (resume sending) |
| clear_i | input | 1 | Empty the buffer and clear error flags |
| wr_valid_i | input | 1 | Received byte strobe |
| wr_data_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Remove the oldest byte |
| rd_data_o | output | 8 | Oldest stored byte |
| level_o | output | 6 | Number of stored bytes |
| empty_o | output | 1 | Buffer empty |
| full_o | output | 1 | Buffer full |
| thr_high_flag_o | output | 1 | Level at or above the high threshold |
| thr_low_flag_o | output | 1 | Level at or below the low threshold |
| overrun_o | output | 1 | Sticky: byte lost to a full buffer |
| ptr_err_o | output | 1 | Sticky: write while full or read while empty |
| rts_o | output | 1 | Request-to-send output |

## Verification
A corrupted pointer or count shows at the ports one edge after the faulty update. It appears either as a wrong level_o or as a byte on rd_data_o that differs from the scoreboard's oldest entry at the next read. A lost or spurious RTS transition appears at the edge where the level crosses a threshold. An RTS state that drifts while the level sits between the thresholds is caught on the following edge. Sticky flags that fail to set or clear are visible one edge after the offending write, read or clear.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned LVL_W  = 6;
  localparam int unsigned BYTE_W = 8;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  flush_i,
  input  logic  push_i,
  input  logic  pop_i,
  input  byte_t din_i,
  output byte_t dout_o,
  output lvl_t  level_o,
  output lvl_t  level_nxt_o,
  output logic  empty_o,
  output logic  full_o,
  output logic  push_drop_o,
  output logic  pop_err_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  byte_t          mem [DEPTH];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           push_ok, pop_ok;

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q == CW'(DEPTH));
  assign push_ok     = push_i & ~full_o;
  assign pop_ok      = pop_i & ~empty_o;
  assign push_drop_o = push_i & full_o;
  assign pop_err_o   = pop_i & empty_o;
  assign dout_o      = mem[rd_ptr_q];

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i)              cnt_d = '0;
    else if (push_ok && !pop_ok) cnt_d = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - CW'(1);
  end

  assign level_o     = LVL_W'(cnt_q);
  assign level_nxt_o = LVL_W'(cnt_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (flush_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= inc_ptr(wr_ptr_q);
        if (pop_ok)  rd_ptr_q <= inc_ptr(rd_ptr_q);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/rxf_rts_hyst.sv
module rxf_rts_hyst
  import rxf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  lvl_t level_q_i,
  input  lvl_t level_nxt_i,
  input  lvl_t thr_high_i,
  input  lvl_t thr_low_i,
  input  logic ctrl_en_i,
  input  logic base_i,
  output logic rts_o
);
  logic state_q, state_d;

  // act only on crossings; hold otherwise
  always_comb begin
    state_d = state_q;
    if (level_q_i < thr_high_i && level_nxt_i >= thr_high_i)     state_d = 1'b1;
    else if (level_q_i > thr_low_i && level_nxt_i <= thr_low_i)  state_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= 1'b0;
    else         state_q <= state_d;
  end

  assign rts_o = ctrl_en_i ? state_q : base_i;
endmodule

// File: rtl/rxf_err_flags.sv
module rxf_err_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic drop_i,
  input  logic bad_pop_i,
  output logic overrun_o,
  output logic ptr_err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      overrun_o <= 1'b0;
      ptr_err_o <= 1'b0;
    end else if (clear_i) begin
      overrun_o <= 1'b0;
      ptr_err_o <= 1'b0;
    end else begin
      if (drop_i)              overrun_o <= 1'b1;
      if (drop_i || bad_pop_i) ptr_err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       rts_ctrl_en_i,
  input  logic       rts_base_i,
  input  logic [5:0] thr_high_i,
  input  logic [5:0] thr_low_i,
  input  logic       clear_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_req_i,
  output logic [7:0] rd_data_o,
  output logic [5:0] level_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       thr_high_flag_o,
  output logic       thr_low_flag_o,
  output logic       overrun_o,
  output logic       ptr_err_o,
  output logic       rts_o
);
  lvl_t level_q, level_nxt;
  logic flush, push, pop, drop, bad_pop;

  assign flush = clear_i | ~fifo_en_i;
  assign push  = wr_valid_i & fifo_en_i & ~clear_i;
  assign pop   = rd_req_i & fifo_en_i & ~clear_i;

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_i      (push),
    .pop_i       (pop),
    .din_i       (wr_data_i),
    .dout_o      (rd_data_o),
    .level_o     (level_q),
    .level_nxt_o (level_nxt),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .push_drop_o (drop),
    .pop_err_o   (bad_pop)
  );

  rxf_rts_hyst u_rts (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .level_q_i   (level_q),
    .level_nxt_i (level_nxt),
    .thr_high_i  (thr_high_i),
    .thr_low_i   (thr_low_i),
    .ctrl_en_i   (rts_ctrl_en_i),
    .base_i      (rts_base_i),
    .rts_o       (rts_o)
  );

  rxf_err_flags u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .drop_i    (drop),
    .bad_pop_i (bad_pop),
    .overrun_o (overrun_o),
    .ptr_err_o (ptr_err_o)
  );

  assign level_o         = level_q;
  assign thr_high_flag_o = (level_q >= thr_high_i);
  assign thr_low_flag_o  = (level_q <= thr_low_i);
endmodule

// File: rtl/rx_fifo_rts_chk.sv
module rx_fifo_rts_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_en_i,
  input logic       rts_ctrl_en_i,
  input logic [5:0] thr_high_i,
  input logic [5:0] thr_low_i,
  input logic       clear_i,
  input logic       wr_valid_i,
  input logic [5:0] level_o,
  input logic       empty_o,
  input logic       full_o,
  input logic       overrun_o,
  input logic       rts_o
);
  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o <= 6'(DEPTH)) && !(empty_o && full_o));

  a_r2_level_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(clear_i) && $past(fifo_en_i)) |->
      ({1'b0, level_o} <= {1'b0, $past(level_o)} + 7'd1) &&
      ({1'b0, level_o} + 7'd1 >= {1'b0, $past(level_o)}));

  a_r3_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && full_o && fifo_en_i && !clear_i) |=> overrun_o);

  a_r3_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !clear_i) |=> overrun_o);

  a_r5_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (level_o == 6'd0) && !overrun_o);

  a_r6_rts_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_ctrl_en_i && $past(level_o) < $past(thr_high_i) &&
     level_o >= $past(thr_high_i)) |-> rts_o);

  a_r7_rts_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_ctrl_en_i && $past(level_o) > $past(thr_low_i) &&
     level_o <= $past(thr_low_i)) |-> !rts_o);

  a_r8_rts_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_ctrl_en_i && $past(rts_ctrl_en_i) &&
     level_o > $past(thr_low_i) && level_o < $past(thr_high_i)) |-> $stable(rts_o));
endmodule

bind rx_fifo_rts rx_fifo_rts_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fifo_en_i     (fifo_en_i),
  .rts_ctrl_en_i (rts_ctrl_en_i),
  .thr_high_i    (thr_high_i),
  .thr_low_i     (thr_low_i),
  .clear_i       (clear_i),
  .wr_valid_i    (wr_valid_i),
  .level_o       (level_o),
  .empty_o       (empty_o),
  .full_o        (full_o),
  .overrun_o     (overrun_o),
  .rts_o         (rts_o)
);

// File: tb/rx_fifo_rts_tb.sv
module rx_fifo_rts_tb;
  localparam int DEPTH = 16;
  localparam int HI = 12;
  localparam int LO = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic fifo_en_i = 1'b1, rts_ctrl_en_i = 1'b1, rts_base_i = 1'b0;
  logic [5:0] thr_high_i = 6'(HI), thr_low_i = 6'(LO);
  logic clear_i = 1'b0, wr_valid_i = 1'b0, rd_req_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [5:0] level_o;
  logic empty_o, full_o, thr_high_flag_o, thr_low_flag_o, overrun_o, ptr_err_o, rts_o;

  always #5 clk_i = ~clk_i;

  rx_fifo_rts #(.DEPTH(DEPTH)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] sb_q[$];
  int  m_lvl = 0;
  bit  m_rts = 0, m_ovr = 0, m_perr = 0;
  logic [7:0] seed = 8'h5a;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic lvl_move(int nl);
    if (m_lvl < HI && nl >= HI) m_rts = 1;
    else if (m_lvl > LO && nl <= LO) m_rts = 0;
    m_lvl = nl;
  endtask

  task automatic chk_state(string req);
    chk({req, " level"}, level_o, m_lvl);
    chk({req, " empty"}, empty_o, m_lvl == 0);
    chk({req, " full"}, full_o, m_lvl == DEPTH);
    chk({req, " rts"}, rts_o, rts_ctrl_en_i ? m_rts : rts_base_i);
    chk({req, " overrun"}, overrun_o, m_ovr);
    chk({req, " ptr_err"}, ptr_err_o, m_perr);
    chk({req, " R10 hi flag"}, thr_high_flag_o, m_lvl >= HI);
    chk({req, " R10 lo flag"}, thr_low_flag_o, m_lvl <= LO);
  endtask

  // driver: pushes expected bytes into the scoreboard
  task automatic push_byte(string req);
    @(negedge clk_i);
    seed = seed * 8'd13 + 8'd7;
    wr_data_i = seed; wr_valid_i = 1'b1;
    if (fifo_en_i) begin
      if (m_lvl < DEPTH) begin
        sb_q.push_back(seed);
        lvl_move(m_lvl + 1);
      end else begin
        m_ovr = 1; m_perr = 1;
      end
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    chk_state(req);
  endtask

  // monitor: compares the presented byte with the scoreboard head
  task automatic pop_byte(string req);
    @(negedge clk_i);
    if (fifo_en_i) begin
      if (m_lvl > 0) begin
        chk({req, " R2 data"}, rd_data_o, sb_q.pop_front());
        lvl_move(m_lvl - 1);
      end else m_perr = 1;
    end
    rd_req_i = 1'b1;
    @(negedge clk_i);
    rd_req_i = 1'b0;
    chk_state(req);
  endtask

  task automatic do_clear(bit with_push, string req);
    @(negedge clk_i);
    clear_i = 1'b1; wr_valid_i = with_push; wr_data_i = 8'hee;
    sb_q.delete();
    lvl_move(0);
    m_ovr = 0; m_perr = 0;
    @(negedge clk_i);
    clear_i = 1'b0; wr_valid_i = 1'b0;
    chk_state(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_state("R1 reset");

    // R2 R6: fill to the high threshold
    for (int i = 0; i < HI - 1; i++) push_byte("R2 fill");
    chk("R6 below high", rts_o, 0);
    push_byte("R6 reach high");
    chk("R6 rts raised", rts_o, 1);

    // R8: drain into the hysteresis band, then refill
    for (int i = 0; i < 3; i++) pop_byte("R8 band pop");
    chk("R8 hold high", rts_o, 1);
    for (int i = 0; i < 3; i++) push_byte("R8 refill");
    for (int i = 0; i < HI - LO - 1; i++) pop_byte("R8 drain");
    chk("R8 still high", rts_o, 1);
    pop_byte("R7 reach low");
    chk("R7 rts dropped", rts_o, 0);
    for (int i = 0; i < HI - LO - 1; i++) push_byte("R8 climb");
    chk("R8 hold low", rts_o, 0);

    // R3: overflow
    while (m_lvl < DEPTH) push_byte("R3 to full");
    push_byte("R3 drop");
    push_byte("R3 drop again");
    chk("R3 level kept", level_o, DEPTH);

    // R2 R4: drain all in order, then underflow
    while (m_lvl > 0) pop_byte("R2 drain");
    pop_byte("R4 read empty");
    chk("R4 ptr_err", ptr_err_o, 1);

    // R5: clear with concurrent write, with bytes and flags pending
    do_clear(1'b0, "R5 clear flags");
    for (int i = 0; i < 5; i++) push_byte("R5 pre");
    do_clear(1'b1, "R5 clear with push");
    pop_byte("R5 after clear read");

    // R9: bypass
    do_clear(1'b0, "R9 prep");
    @(negedge clk_i); rts_ctrl_en_i = 1'b0; rts_base_i = 1'b1;
    @(negedge clk_i); chk("R9 bypass high", rts_o, 1);
    rts_base_i = 1'b0;
    @(negedge clk_i); chk("R9 bypass low", rts_o, 0);
    rts_ctrl_en_i = 1'b1;

    // R11: disabled buffer ignores traffic
    for (int i = 0; i < 3; i++) push_byte("R11 pre");
    @(negedge clk_i); fifo_en_i = 1'b0;
    sb_q.delete(); lvl_move(0);
    push_byte("R11 push ignored");
    pop_byte("R11 pop ignored");
    @(negedge clk_i); fifo_en_i = 1'b1;
    @(negedge clk_i);
    chk_state("R11 reenabled");
    push_byte("R11 push works");
    pop_byte("R11 pop works");

    done = 1;
    finish_run();
  end
endmodule